// File: doc/BRIEF.md
# Parallel-Port Bitstream Loader Registers

This block is a two-register slave on an 8-bit parallel host bus. The bus carries address and data on the same lines and uses separate address and data strobes, a write-direction line and a wait acknowledge. While the target device is still unconfigured, the host uses the block to pulse the device's active-low program line. It then streams the bitstream one byte at a time into a byte-wide configuration port. Before streaming, the host can read a strap that tells it the device size.

An address-strobe cycle stores the bus byte in an internal address register, and that register can also be read back. Data-strobe cycles then act on the register that the stored address selects. Address 1 is the control register. A write sends bit 0 to the program output, and a read returns the done status in bit 0. Address 0 is the data register. A write hands the byte to the configuration port with a one-cycle write pulse, and a read returns the size strap in bit 0. All strobes and the done input pass through synchronizers. After the synchronized done goes high, the block stops answering and releases both the data bus and the wait line.

Top module: `cfg_loader_regs`

## Requirements
- R1: After reset, prog_no_o is 1, bus_wait_o is 0, bus_d_oe_o is 0, and an address-register read returns 0.
- R2: An address-strobe write (bus_write_ni low) stores the 8-bit bus value in the address register. An address-strobe read (bus_write_ni high) returns that stored value.
- R3: A data-strobe write while the address is 1 copies bus bit 0 to prog_no_o. Other register writes leave prog_no_o unchanged.
- R4: A data-strobe read at address 1 returns the synchronized done in bit 0 and zeros in bits 7..1.
- R5: A data-strobe write at address 0 raises cfg_wr_o for exactly one cycle. In that cycle cfg_data_o carries the written byte, and cfg_data_o keeps that value until the next such write.
- R6: A data-strobe read at address 0 returns size_strap_i in bit 0 (1 = larger device, 0 = smaller device) and zeros in bits 7..1.
- R7: At any address other than 0 or 1, data-strobe writes have no effect (no cfg_wr_o pulse, prog_no_o unchanged) and data-strobe reads return 0.
- R8: bus_wait_o goes high within SYNC_STAGES+2 cycles after a strobe falls, and it goes high only while a synchronized strobe is active. It returns low within SYNC_STAGES+2 cycles after both strobes are high.
- R9: bus_d_oe_o is high only during an accepted read whose strobe is still low. It stays low for every write.
- R10: Once done_i has been high for SYNC_STAGES cycles, bus_wait_oe_o and bus_d_oe_o are 0, bus_wait_o is 0, and strobes have no effect on prog_no_o or cfg_wr_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_d_i | input | 8 | Host bus data/address in |
| bus_d_o | output | 8 | Read data to host bus |
| bus_d_oe_o | output | 1 | Drive enable for bus_d_o |
| bus_write_ni | input | 1 | Direction: low = host write |
| bus_astb_ni | input | 1 | Address strobe, active low |
| bus_dstb_ni | input | 1 | Data strobe, active low |
| bus_wait_o | output | 1 | Acknowledge to host, high = access accepted |
| bus_wait_oe_o | output | 1 | Drive enable for bus_wait_o |
| prog_no_o | output | 1 | Device program line, active low |
| done_i | input | 1 | Device configuration done |
| cfg_data_o | output | 8 | Configuration byte |
| cfg_wr_o | output | 1 | One-cycle configuration byte strobe |
| size_strap_i | input | 1 | Device size strap |

## Verification
The hardest state to reach from the ports is the hand-off when done rises: a strobe is held low across and after the synchronizer delay, yet the block must neither acknowledge nor touch the program line or the configuration port. The bench reaches this state at the end of the run. It raises done, waits out the synchronizer, holds a data-strobe write low for many cycles, and checks wait, both enables, the pulse count and the program level. Before that, seeded random cycles visit every address class with random bytes and strap values, so writes to unmapped addresses and program toggles fall between real data writes.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  localparam int unsigned BUS_W     = 8;
  localparam int unsigned SYNC_N    = 2;
  localparam int unsigned ADDR_DATA = 0;
  localparam int unsigned ADDR_CTL  = 1;

  typedef enum logic {HS_IDLE, HS_ACK} hs_state_e;
endpackage

// File: rtl/lp_sync.sv
module lp_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= RST_VAL;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/lp_handshake.sv
module lp_handshake
  import cfg_loader_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic astb_s_ni,
  input  logic dstb_s_ni,
  input  logic wr_s_i,
  input  logic done_s_i,
  output logic accept_o,
  output logic is_addr_o,
  output logic is_addr_q_o,
  output logic rd_q_o,
  output logic ack_o
);
  hs_state_e state_q, state_d;
  logic strobe_act;

  assign strobe_act = !astb_s_ni || !dstb_s_ni;
  assign accept_o   = (state_q == HS_IDLE) && !done_s_i && strobe_act;
  assign is_addr_o  = !astb_s_ni;
  assign ack_o      = (state_q == HS_ACK);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      HS_IDLE: if (accept_o) state_d = HS_ACK;
      HS_ACK:  if (done_s_i || !strobe_act) state_d = HS_IDLE;
      default: state_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= HS_IDLE;
      is_addr_q_o <= 1'b0;
      rd_q_o      <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept_o) begin
        is_addr_q_o <= is_addr_o;
        rd_q_o      <= !wr_s_i;
      end
    end
  end
endmodule

// File: rtl/lp_regs.sv
module lp_regs
  import cfg_loader_pkg::*;
#(
  parameter int unsigned DW = BUS_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  logic          is_addr_i,
  input  logic          wr_i,
  input  logic [DW-1:0] d_i,
  input  logic          is_addr_q_i,
  input  logic          done_s_i,
  input  logic          size_i,
  output logic          prog_no_o,
  output logic [DW-1:0] cfg_data_o,
  output logic          cfg_wr_o,
  output logic [DW-1:0] rd_data_o
);
  localparam logic [DW-1:0] A_CTL  = DW'(ADDR_CTL);
  localparam logic [DW-1:0] A_DATA = DW'(ADDR_DATA);

  logic [DW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q     <= '0;
      prog_no_o  <= 1'b1;
      cfg_data_o <= '0;
      cfg_wr_o   <= 1'b0;
    end else begin
      cfg_wr_o <= 1'b0;
      if (accept_i && wr_i) begin
        if (is_addr_i) addr_q <= d_i;
        else if (addr_q == A_CTL) prog_no_o <= d_i[0];
        else if (addr_q == A_DATA) begin
          cfg_data_o <= d_i;
          cfg_wr_o   <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (is_addr_q_i) rd_data_o = addr_q;
    else if (addr_q == A_CTL) rd_data_o[0] = done_s_i;
    else if (addr_q == A_DATA) rd_data_o[0] = size_i;
  end
endmodule

// File: rtl/cfg_loader_regs.sv
module cfg_loader_regs
  import cfg_loader_pkg::*;
#(
  parameter int unsigned DW          = BUS_W,
  parameter int unsigned SYNC_STAGES = SYNC_N
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] bus_d_i,
  output logic [DW-1:0] bus_d_o,
  output logic          bus_d_oe_o,
  input  logic          bus_write_ni,
  input  logic          bus_astb_ni,
  input  logic          bus_dstb_ni,
  output logic          bus_wait_o,
  output logic          bus_wait_oe_o,
  output logic          prog_no_o,
  input  logic          done_i,
  output logic [DW-1:0] cfg_data_o,
  output logic          cfg_wr_o,
  input  logic          size_strap_i
);
  logic astb_s_n, dstb_s_n, write_s_n, done_s;
  logic wr_s, accept, is_addr, is_addr_q, rd_q, ack;

  lp_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0111)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({done_i, bus_write_ni, bus_dstb_ni, bus_astb_ni}),
    .q_o   ({done_s, write_s_n, dstb_s_n, astb_s_n})
  );

  assign wr_s = !write_s_n;

  lp_handshake i_hs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .astb_s_ni  (astb_s_n),
    .dstb_s_ni  (dstb_s_n),
    .wr_s_i     (wr_s),
    .done_s_i   (done_s),
    .accept_o   (accept),
    .is_addr_o  (is_addr),
    .is_addr_q_o(is_addr_q),
    .rd_q_o     (rd_q),
    .ack_o      (ack)
  );

  lp_regs #(.DW(DW)) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .is_addr_i  (is_addr),
    .wr_i       (wr_s),
    .d_i        (bus_d_i),
    .is_addr_q_i(is_addr_q),
    .done_s_i   (done_s),
    .size_i     (size_strap_i),
    .prog_no_o  (prog_no_o),
    .cfg_data_o (cfg_data_o),
    .cfg_wr_o   (cfg_wr_o),
    .rd_data_o  (bus_d_o)
  );

  // drive only while the host still holds the read strobe
  assign bus_d_oe_o    = ack && rd_q && !done_s && (!bus_astb_ni || !bus_dstb_ni);
  assign bus_wait_o    = ack && !done_s;
  assign bus_wait_oe_o = !done_s;
endmodule

// File: rtl/cfg_loader_regs_chk.sv
module cfg_loader_regs_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          bus_write_ni,
  input logic          bus_d_oe_o,
  input logic          bus_wait_o,
  input logic          bus_wait_oe_o,
  input logic          prog_no_o,
  input logic          cfg_wr_o,
  input logic [DW-1:0] cfg_data_o,
  input logic          astb_s_n,
  input logic          dstb_s_n,
  input logic          done_s,
  input logic          accept,
  input logic          wr_s
);
  // R5
  cfg_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_o |=> !cfg_wr_o);

  // R5
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_wr_o |-> $stable(cfg_data_o));

  // R3
  prog_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_no_o != $past(prog_no_o)) |-> ($past(accept) && $past(wr_s)));

  // R8
  wait_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_wait_o) |-> (!astb_s_n || !dstb_s_n));

  // R9
  read_only_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_d_oe_o |-> (bus_write_ni && bus_wait_o));

  // R10
  inert_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_s |-> (!bus_wait_oe_o && !bus_d_oe_o && !bus_wait_o));

  // R10
  inert_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_s |=> !cfg_wr_o);
endmodule

bind cfg_loader_regs cfg_loader_regs_chk #(.DW(DW)) i_chk (.*);

// File: tb/test_cfg_loader_regs.sv
module test_cfg_loader_regs;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 20;

  logic clk = 0, rst_n = 0;
  logic [7:0] d_i = 0, d_o, cfg_data;
  logic d_oe, write_n = 1, astb_n = 1, dstb_n = 1, wait_o, wait_oe;
  logic prog_n, done = 0, cfg_wr, strap = 0;

  int nchk = 0, nerr = 0, pulses = 0;
  logic [7:0] last_cfg = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_loader_regs i_cfg_loader_regs (
    .clk_i(clk), .rst_ni(rst_n), .bus_d_i(d_i), .bus_d_o(d_o), .bus_d_oe_o(d_oe),
    .bus_write_ni(write_n), .bus_astb_ni(astb_n), .bus_dstb_ni(dstb_n),
    .bus_wait_o(wait_o), .bus_wait_oe_o(wait_oe), .prog_no_o(prog_n),
    .done_i(done), .cfg_data_o(cfg_data), .cfg_wr_o(cfg_wr), .size_strap_i(strap)
  );

  always @(negedge clk) if (cfg_wr) begin pulses++; last_cfg = cfg_data; end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(logic [7:0] a, bit is_a, bit s);
    if (is_a) return a;
    if (a == 8'd1) return 8'h00;
    if (a == 8'd0) return {7'b0, s};
    return 8'h00;
  endfunction

  task automatic bus_cycle(input bit is_a, input bit is_wr, input logic [7:0] wd,
                           output logic [7:0] rd, output bit got);
    int n;
    @(negedge clk);
    write_n = !is_wr; d_i = wd;
    @(negedge clk);
    if (is_a) astb_n = 0; else dstb_n = 0;
    got = 0; n = 0;
    while (!got && n < TMO) begin
      @(negedge clk); n++;
      if (wait_o) got = 1;
    end
    chk(got, "R8 wait rise", int'(got), 1);
    rd = d_oe ? d_o : 8'hxx;
    if (is_wr) chk(!d_oe, "R9 no drive on write", int'(d_oe), 0);
    else chk(d_oe, "R9 drive on read", int'(d_oe), 1);
    astb_n = 1; dstb_n = 1;
    #1 chk(!d_oe, "R9 release after strobe", int'(d_oe), 0);
    n = 0;
    while (wait_o && n < TMO) begin @(negedge clk); n++; end
    chk(!wait_o, "R8 wait fall", int'(wait_o), 0);
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    logic [7:0] rd, ea, wd;
    logic ep;
    bit got;
    int ep_cnt;
    void'($urandom(32'h1c4d));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(prog_n == 1, "R1 prog reset", prog_n, 1);
    chk(!wait_o && !d_oe, "R1 idle bus", {wait_o, d_oe}, 0);
    bus_cycle(1, 0, 8'h00, rd, got);
    chk(rd == 8'h00, "R1 addr reset", rd, 0);

    // directed host sequence
    bus_cycle(1, 1, 8'h01, rd, got);
    bus_cycle(0, 1, 8'h00, rd, got);
    chk(prog_n == 0, "R3 prog low", prog_n, 0);
    bus_cycle(0, 1, 8'hFF, rd, got);
    chk(prog_n == 1, "R3 prog high", prog_n, 1);
    bus_cycle(0, 0, 8'h00, rd, got);
    chk(rd == 8'h00, "R4 done read", rd, 0);
    bus_cycle(1, 1, 8'h00, rd, got);
    strap = 1;
    bus_cycle(0, 0, 8'h00, rd, got);
    chk(rd == 8'h01, "R6 size large", rd, 1);
    strap = 0;
    bus_cycle(0, 0, 8'h00, rd, got);
    chk(rd == 8'h00, "R6 size small", rd, 0);
    ep_cnt = pulses;
    bus_cycle(0, 1, 8'hFF, rd, got);
    chk(pulses == ep_cnt + 1 && last_cfg == 8'hFF, "R5 byte ff", last_cfg, 8'hFF);
    bus_cycle(0, 1, 8'h00, rd, got);
    chk(pulses == ep_cnt + 2 && last_cfg == 8'h00, "R5 byte 00", last_cfg, 0);
    bus_cycle(1, 1, 8'h02, rd, got);
    bus_cycle(0, 1, 8'h00, rd, got);
    chk(pulses == ep_cnt + 2 && prog_n == 1, "R7 unmapped write", pulses, ep_cnt + 2);
    bus_cycle(0, 0, 8'h00, rd, got);
    chk(rd == 8'h00, "R7 unmapped read", rd, 0);
    bus_cycle(1, 0, 8'h00, rd, got);
    chk(rd == 8'h02, "R2 addr readback", rd, 2);

    // random traffic
    ea = 8'h02; ep = 1; ep_cnt = pulses;
    for (int i = 0; i < 300; i++) begin
      int kind = $urandom_range(0, 4);
      strap = 1'($urandom);
      wd = 8'($urandom);
      case (kind)
        0: begin
          wd = ($urandom_range(0, 2) == 0) ? wd : 8'($urandom_range(0, 1));
          bus_cycle(1, 1, wd, rd, got); ea = wd;
        end
        1: begin
          bus_cycle(0, 1, wd, rd, got);
          if (ea == 8'd1) ep = wd[0];
          else if (ea == 8'd0) begin
            ep_cnt++;
            chk(last_cfg == wd, "R5 random byte", last_cfg, wd);
          end
          chk(prog_n == ep, "R3 random prog", prog_n, ep);
          chk(pulses == ep_cnt, "R5 R7 pulse count", pulses, ep_cnt);
        end
        2, 3: begin
          bus_cycle(0, 0, 8'h00, rd, got);
          chk(rd == exp_read(ea, 0, strap), "R4 R6 R7 random read", rd, exp_read(ea, 0, strap));
        end
        default: begin
          bus_cycle(1, 0, 8'h00, rd, got);
          chk(rd == ea, "R2 random addr read", rd, ea);
        end
      endcase
    end

    // done hand-off
    bus_cycle(1, 1, 8'h00, rd, got);
    ep_cnt = pulses; ep = prog_n;
    done = 1;
    repeat (4) @(negedge clk);
    chk(!wait_oe && !d_oe && !wait_o, "R10 released", {wait_oe, d_oe, wait_o}, 0);
    write_n = 0; d_i = 8'h5A;
    @(negedge clk); dstb_n = 0;
    repeat (12) begin
      @(negedge clk);
      chk(!wait_o && !wait_oe && !d_oe, "R10 no ack", {wait_o, wait_oe, d_oe}, 0);
    end
    dstb_n = 1; write_n = 1;
    repeat (3) @(negedge clk);
    chk(pulses == ep_cnt, "R10 no pulse", pulses, ep_cnt);
    chk(prog_n == ep, "R10 prog kept", prog_n, ep);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule